// File: doc/BRIEF.md
# Four-Way I2C Bus Switch Target

This block is an I2C target that connects one upstream I2C bus to at most one of four downstream buses. It holds a single control register. A controller upstream sets the register by addressing the switch for a write, sending one control byte and closing with a stop. In a later, separate transaction it talks to a device on the selected downstream bus through the switch. A read of the switch returns the current selection as one byte.

All bus lines are open-drain. The block sees each line through a sampled input and pulls it low through an enable output. Upstream SCL and SDA pass through a two-flop synchronizer before start, stop and bit decoding. Routing is digital: a low seen on one side of an enabled channel is repeated onto the other side. A small direction tracker on each line keeps the repeated low from latching itself.

Top module: `i2c_chan_switch`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 111000 followed by `addr_sel_i`. Any other address is left unacknowledged with SDA released, and the rest of that transaction is ignored.
- R2: Each control byte written after a matching write address (R/W bit 0) is acknowledged. Bit 2 is the enable flag and bits 1:0 are the channel index. The last byte written becomes the selection at the following stop condition, and not before.
- R3: A control byte with bit 2 clear, including all zero, leaves every downstream channel disconnected.
- R4: When a new start condition arrives before the stop, a control byte already written is discarded and the previous selection stays in force.
- R5: A read (R/W bit 1) returns one byte equal to {5'b00000, enable, index[1:0]}. Bits 7:3 of a written byte are ignored and read back as zero. After the controller NACKs the byte, the target leaves SDA released.
- R6: After reset no line is pulled low, no channel is connected, and a read returns 0x00.
- R7: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged on the synchronized upstream lines. A repeated start restarts address decoding.
- R8: While channel k is enabled, a low driven upstream on SCL or SDA is repeated as a pull-low on downstream pair k. A low driven by a device on pair k is repeated upstream.
- R9: Channels other than the enabled one are never pulled low, and lows on their lines never reach the upstream bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the I2C bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel_i | input | 1 | Strap that sets the lowest address bit |
| up_scl_i | input | 1 | Sampled upstream SCL |
| up_sda_i | input | 1 | Sampled upstream SDA |
| up_scl_pd_o | output | 1 | Pull upstream SCL low |
| up_sda_pd_o | output | 1 | Pull upstream SDA low |
| dn_scl_i | input | 4 | Sampled downstream SCL, one bit per channel |
| dn_sda_i | input | 4 | Sampled downstream SDA, one bit per channel |
| dn_scl_pd_o | output | 4 | Pull downstream SCL low, one bit per channel |
| dn_sda_pd_o | output | 4 | Pull downstream SDA low, one bit per channel |

## Verification
A bit counter or shift register that drifts out of step moves the acknowledge bit. The controller then samples SDA high where a low was due, within the same byte, or a read-back byte arrives shifted. If the control register takes a byte early, or keeps one after a repeated start, the very next read returns the wrong value. A route decoded from the wrong register bits shows as a pull-low on the wrong downstream pair a few clocks after the controller drives SCL low. A direction tracker that fails to release holds a line low after the stimulus has gone.

// File: rtl/i2c_sw_pkg.sv
// Package: shared state types for the I2C bus switch.
// Assumes: consumers import it; no logic here.
package i2c_sw_pkg;

    // Target protocol states.
    typedef enum logic [2:0] {
        T_IDLE  = 3'd0,
        T_ADDR  = 3'd1,
        T_AACK  = 3'd2,
        T_WDATA = 3'd3,
        T_WACK  = 3'd4,
        T_RDATA = 3'd5,
        T_RACK  = 3'd6
    } tgt_state_e;

    // Per-line direction tracker states.
    typedef enum logic [1:0] {
        L_IDLE  = 2'd0,
        L_UP    = 2'd1,
        L_DN    = 2'd2,
        L_RECOV = 2'd3
    } lane_state_e;

endpackage

// File: rtl/i2c_sw_sync.sv
// Module: multi-bit synchronizer chain for open-drain line samples.
// Assumes: each bit is an independent slow line; reset value is the
// released (high) level so no false edges appear after reset.
module i2c_sw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift every line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '1;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_sw_target.sv
// Module: I2C target protocol engine with one control register.
// Assumes: scl_i/sda_i are already synchronized; no clock stretching;
// the control register is CH_W+1 bits wide (enable above the index).
module i2c_sw_target
    import i2c_sw_pkg::*;
#(
    parameter int         CH_W    = 2,
    parameter logic [5:0] ADDR_HI = 6'b111000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          strap_i,
    output logic          sda_pd_o,
    output logic [CH_W:0] ctrl_o,
    output logic          stop_o
);
    localparam int CTRL_W = CH_W + 1;

    logic              scl_q, sda_q;
    logic              scl_rise, scl_fall, start_det, stop_det;
    tgt_state_e        st;
    logic [7:0]        sh;
    logic [3:0]        cnt;
    logic              rw_q;
    logic [CTRL_W-1:0] pend_q;
    logic              pend_v;
    logic [CTRL_W-1:0] ctrl_q;
    logic              sda_pd;
    logic [7:0]        rd_byte;

    // Keep the previous synchronized line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    assign rd_byte   = {{(8-CTRL_W){1'b0}}, ctrl_q};

    // Protocol sequencing, acknowledge drive and register commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= T_IDLE;
            sh     <= '0;
            cnt    <= '0;
            rw_q   <= 1'b0;
            pend_q <= '0;
            pend_v <= 1'b0;
            ctrl_q <= '0;
            sda_pd <= 1'b0;
        end else if (start_det) begin
            st     <= T_ADDR;
            cnt    <= '0;
            pend_v <= 1'b0;
            sda_pd <= 1'b0;
        end else if (stop_det) begin
            st     <= T_IDLE;
            sda_pd <= 1'b0;
            pend_v <= 1'b0;
            if (pend_v) ctrl_q <= pend_q;
        end else begin
            case (st)
                T_ADDR, T_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_i};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        if (st == T_ADDR) begin
                            if (sh[7:1] == {ADDR_HI, strap_i}) begin
                                st     <= T_AACK;
                                sda_pd <= 1'b1;
                                rw_q   <= sh[0];
                            end else begin
                                st <= T_IDLE;
                            end
                        end else begin
                            st     <= T_WACK;
                            sda_pd <= 1'b1;
                            pend_q <= sh[CTRL_W-1:0];
                            pend_v <= 1'b1;
                        end
                    end
                end
                T_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw_q) begin
                            st     <= T_RDATA;
                            sh     <= rd_byte;
                            sda_pd <= ~rd_byte[7];
                        end else begin
                            st     <= T_WDATA;
                            sda_pd <= 1'b0;
                        end
                    end
                end
                T_WACK: begin
                    if (scl_fall) begin
                        st     <= T_WDATA;
                        cnt    <= '0;
                        sda_pd <= 1'b0;
                    end
                end
                T_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            st     <= T_RACK;
                            sda_pd <= 1'b0;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_pd <= ~sh[6];
                        end
                    end
                end
                T_RACK: begin
                    if (scl_rise && sda_i) begin
                        st <= T_IDLE;
                    end else if (scl_fall) begin
                        st     <= T_RDATA;
                        cnt    <= '0;
                        sh     <= rd_byte;
                        sda_pd <= ~rd_byte[7];
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign sda_pd_o = sda_pd;
    assign ctrl_o   = ctrl_q;
    assign stop_o   = stop_det;
endmodule

// File: rtl/i2c_sw_lane.sv
// Module: direction tracker that repeats lows across one enabled line pair.
// Assumes: synchronized inputs; the first side seen low owns the line until
// it releases, then both sides must read high before a new owner is taken.
module i2c_sw_lane
    import i2c_sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic up_i,
    input  logic dn_i,
    output logic dn_pd_o,
    output logic up_pd_o
);
    lane_state_e st;

    // Track which side currently drives the shared low.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st <= L_RECOV;
        end else begin
            case (st)
                L_IDLE: begin
                    if (!up_i)      st <= L_UP;
                    else if (!dn_i) st <= L_DN;
                end
                L_UP:    if (up_i) st <= L_RECOV;
                L_DN:    if (dn_i) st <= L_RECOV;
                default: if (up_i && dn_i) st <= L_IDLE;
            endcase
        end
    end

    assign dn_pd_o = (st == L_UP);
    assign up_pd_o = (st == L_DN);
endmodule

// File: rtl/i2c_chan_switch.sv
// Module: top of the four-way I2C bus switch target.
// Assumes: all lines are open-drain with external pull-ups; clk runs at
// least ~20x the SCL rate so synchronizer delay stays inside bit phases.
module i2c_chan_switch
    import i2c_sw_pkg::*;
#(
    parameter int         N_CH        = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b111000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_sel_i,
    input  logic            up_scl_i,
    input  logic            up_sda_i,
    output logic            up_scl_pd_o,
    output logic            up_sda_pd_o,
    input  logic [N_CH-1:0] dn_scl_i,
    input  logic [N_CH-1:0] dn_sda_i,
    output logic [N_CH-1:0] dn_scl_pd_o,
    output logic [N_CH-1:0] dn_sda_pd_o
);
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int SYNC_W = 2 + 2 * N_CH;

    logic [SYNC_W-1:0] raw, syn;
    logic              up_scl_s, up_sda_s;
    logic [N_CH-1:0]   dn_scl_s, dn_sda_s;
    logic [CH_W:0]     ctrl_q;
    logic              stop_det;
    logic              tgt_sda_pd;
    logic [N_CH-1:0]   up_scl_req, up_sda_req;

    assign raw = {dn_sda_i, dn_scl_i, up_sda_i, up_scl_i};

    i2c_sw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign up_scl_s = syn[0];
    assign up_sda_s = syn[1];
    assign dn_scl_s = syn[2 +: N_CH];
    assign dn_sda_s = syn[2 + N_CH +: N_CH];

    i2c_sw_target #(.CH_W(CH_W), .ADDR_HI(ADDR_HI)) u_tgt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (up_scl_s),
        .sda_i    (up_sda_s),
        .strap_i  (addr_sel_i),
        .sda_pd_o (tgt_sda_pd),
        .ctrl_o   (ctrl_q),
        .stop_o   (stop_det)
    );

    // One SCL tracker and one SDA tracker per downstream channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic ch_en;
        assign ch_en = ctrl_q[CH_W] && (ctrl_q[CH_W-1:0] == CH_W'(i));

        i2c_sw_lane u_scl (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ch_en),
            .up_i    (up_scl_s),
            .dn_i    (dn_scl_s[i]),
            .dn_pd_o (dn_scl_pd_o[i]),
            .up_pd_o (up_scl_req[i])
        );

        i2c_sw_lane u_sda (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ch_en),
            .up_i    (up_sda_s),
            .dn_i    (dn_sda_s[i]),
            .dn_pd_o (dn_sda_pd_o[i]),
            .up_pd_o (up_sda_req[i])
        );
    end

    assign up_scl_pd_o = |up_scl_req;
    assign up_sda_pd_o = tgt_sda_pd | (|up_sda_req);
endmodule

// File: rtl/i2c_chan_switch_chk.sv
// Module: property checker bound to the bus switch top.
// Assumes: ctrl_q holds {enable, index}; stop_det is the one-cycle stop pulse.
module i2c_chan_switch_chk #(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CH_W:0]   ctrl_q,
    input logic            stop_det,
    input logic            up_scl_pd_o,
    input logic            up_sda_pd_o,
    input logic [N_CH-1:0] dn_scl_pd_o,
    input logic [N_CH-1:0] dn_sda_pd_o
);
    logic [N_CH-1:0] sel;

    // Decode which channel the register selects.
    always_comb begin
        for (int i = 0; i < N_CH; i++)
            sel[i] = ctrl_q[CH_W] && (ctrl_q[CH_W-1:0] == CH_W'(i));
    end

    // R2: the selection only changes on the cycle after a stop.
    p_commit_at_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> $past(stop_det));

    // R6: nothing is pulled low in the first cycle out of reset.
    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dn_scl_pd_o == '0 && dn_sda_pd_o == '0
                           && !up_scl_pd_o && !up_sda_pd_o));

    // R9: at most one downstream channel is ever driven.
    p_single_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_scl_pd_o | dn_sda_pd_o));

    // R9: upstream SCL is never pulled while routing is off.
    p_scl_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CH_W] && !$past(ctrl_q[CH_W])) |-> !up_scl_pd_o);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R9: an unselected channel carries no pull-low.
        p_unsel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel[i] && !$past(sel[i])) |-> (!dn_scl_pd_o[i] && !dn_sda_pd_o[i]));
    end
endmodule

bind i2c_chan_switch i2c_chan_switch_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_q),
    .stop_det    (stop_det),
    .up_scl_pd_o (up_scl_pd_o),
    .up_sda_pd_o (up_sda_pd_o),
    .dn_scl_pd_o (dn_scl_pd_o),
    .dn_sda_pd_o (dn_sda_pd_o)
);

// File: tb/i2c_chan_switch_tb.sv
// Bench: upstream controller model plus static downstream line drivers;
// directed corner cases followed by seeded random selections.
module i2c_chan_switch_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic [3:0] s_scl = 4'hF, s_sda = 4'hF;
    logic       up_scl_pd, up_sda_pd;
    logic [3:0] dn_scl_pd, dn_sda_pd;
    logic       up_scl, up_sda;
    logic [3:0] dn_scl, dn_sda;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign up_scl = m_scl & ~up_scl_pd;
    assign up_sda = m_sda & ~up_sda_pd;
    assign dn_scl = s_scl & ~dn_scl_pd;
    assign dn_sda = s_sda & ~dn_sda_pd;

    i2c_chan_switch u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_sel_i  (strap),
        .up_scl_i    (up_scl),
        .up_sda_i    (up_sda),
        .up_scl_pd_o (up_scl_pd),
        .up_sda_pd_o (up_sda_pd),
        .dn_scl_i    (dn_scl),
        .dn_sda_i    (dn_sda),
        .dn_scl_pd_o (dn_scl_pd),
        .dn_sda_pd_o (dn_sda_pd)
    );

    function automatic logic [7:0] addr_byte(input logic s, input logic rw);
        return {6'b111000, s, rw};
    endfunction
    function automatic logic [7:0] exp_rb(input logic [7:0] w);
        return {5'b00000, w[2:0]};
    endfunction
    function automatic logic [3:0] exp_route(input logic [7:0] w);
        return w[2] ? (4'b0001 << w[1:0]) : 4'b0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic clk_bit(input logic d, output logic s);
        m_sda = d; tick(Q);
        m_scl = 1'b1; tick(Q);
        s = up_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(1'b1, s);   // controller NACK
    endtask

    task automatic write_ctrl(input logic [7:0] b, output logic aa, output logic da);
        bus_start();
        wr_byte(addr_byte(strap, 1'b0), aa);
        da = 1'b0;
        if (aa) wr_byte(b, da);
        bus_stop();
    endtask

    task automatic read_ctrl(output logic [7:0] v, output logic aa);
        bus_start();
        wr_byte(addr_byte(strap, 1'b1), aa);
        v = 8'hXX;
        if (aa) begin
            rd_byte(v);
            tick(4);
            check("R5 sda released after nack", {31'd0, up_sda_pd}, 32'd0);
        end
        bus_stop();
    endtask

    // Pull upstream SCL low and compare the downstream pull pattern.
    task automatic probe_down(input string req, input logic [3:0] exp);
        m_scl = 1'b0; tick(8);
        check(req, {28'd0, dn_scl_pd}, {28'd0, exp});
        m_scl = 1'b1; tick(8);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic       aa, da;
        logic [7:0] v, w;
        int         j;
        void'($urandom(32'h1c2a));
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R6: reset state.
        check("R6 dn pulls", {24'd0, dn_scl_pd, dn_sda_pd}, 32'd0);
        check("R6 up pulls", {30'd0, up_scl_pd, up_sda_pd}, 32'd0);
        read_ctrl(v, aa);
        check("R1 read addr ack", {31'd0, aa}, 32'd1);
        check("R6 reset readback", {24'd0, v}, 32'd0);
        probe_down("R6 no route after reset", 4'b0000);

        // R1: mismatched addresses are not acknowledged.
        bus_start();
        wr_byte(addr_byte(~strap, 1'b0), aa);
        bus_stop();
        check("R1 strap mismatch nack", {31'd0, aa}, 32'd0);
        bus_start();
        wr_byte(8'hA0, aa);
        wr_byte(8'h06, da);
        bus_stop();
        check("R1 foreign addr nack", {31'd0, aa}, 32'd0);
        check("R1 foreign data nack", {31'd0, da}, 32'd0);

        // R2, R8: select channel 2 and exercise both directions.
        write_ctrl(8'h06, aa, da);
        check("R2 data ack", {31'd0, da}, 32'd1);
        probe_down("R8 scl down ch2", 4'b0100);
        m_scl = 1'b0; tick(4);
        m_sda = 1'b0; tick(8);
        check("R8 sda down ch2", {28'd0, dn_sda_pd}, 32'h4);
        m_sda = 1'b1; tick(8);
        m_scl = 1'b1; tick(8);
        s_scl[2] = 1'b0; tick(8);
        check("R8 scl up from ch2", {31'd0, up_scl_pd}, 32'd1);
        s_scl[2] = 1'b1; tick(8);
        check("R8 scl up released", {31'd0, up_scl_pd}, 32'd0);
        s_scl[1] = 1'b0; tick(8);
        check("R9 ch1 blocked", {31'd0, up_scl_pd}, 32'd0);
        s_scl[1] = 1'b1; tick(8);

        // R4, R7: repeated start before stop drops the written byte.
        bus_start();
        wr_byte(addr_byte(strap, 1'b0), aa);
        wr_byte(8'h05, da);
        bus_start();
        wr_byte(addr_byte(strap, 1'b1), aa);
        check("R7 repeated start addr ack", {31'd0, aa}, 32'd1);
        rd_byte(v);
        bus_stop();
        check("R4 old value during abort", {24'd0, v}, 32'h06);
        read_ctrl(v, aa);
        check("R4 old value kept", {24'd0, v}, 32'h06);

        // R5, R3: upper bits ignored; enable clear disconnects.
        write_ctrl(8'hFB, aa, da);
        read_ctrl(v, aa);
        check("R5 upper bits read zero", {24'd0, v}, 32'h03);
        probe_down("R3 enable clear", 4'b0000);
        write_ctrl(8'hFD, aa, da);
        read_ctrl(v, aa);
        check("R5 readback ch1", {24'd0, v}, 32'h05);
        probe_down("R8 route ch1", 4'b0010);
        write_ctrl(8'h00, aa, da);
        read_ctrl(v, aa);
        check("R3 all zero readback", {24'd0, v}, 32'h00);
        probe_down("R3 all zero route", 4'b0000);

        // R2: two data bytes in one write, last one wins.
        bus_start();
        wr_byte(addr_byte(strap, 1'b0), aa);
        wr_byte(8'h04, da);
        wr_byte(8'h07, da);
        check("R2 second byte ack", {31'd0, da}, 32'd1);
        bus_stop();
        read_ctrl(v, aa);
        check("R2 last byte wins", {24'd0, v}, 32'h07);

        // Random selections with strap changes.
        for (int k = 0; k < 24; k++) begin
            strap = 1'($urandom);
            w = 8'($urandom);
            write_ctrl(w, aa, da);
            check("R2 random data ack", {31'd0, da}, 32'd1);
            read_ctrl(v, aa);
            check("R5 random readback", {24'd0, v}, {24'd0, exp_rb(w)});
            probe_down("R8 random route", exp_route(w));
            j = int'($urandom % 4);
            s_scl[j] = 1'b0; tick(8);
            check("R9 random upstream reflect", {31'd0, up_scl_pd},
                  {31'd0, exp_route(w)[j]});
            s_scl[j] = 1'b1; tick(8);
        end

        finish_run();
    end
endmodule